// File: doc/BRIEF.md
# TDM Bit-Clock and Frame-Sync Timing Generator

This block sets the timing of a time-division-multiplexed PCM voice port. In master mode it divides a fast system clock down to a bit clock. It counts bit periods across a frame made of a programmable number of 8-bit slots, and it drives a frame sync pulse. The pulse is either half a bit period wide or spans several bit periods, and it can change on either edge of the bit clock.

In slave mode the block does not drive the bit clock or the frame sync. It synchronizes an external bit clock and frame sync into the system clock domain and keeps the same bit-position count from them. A sync edge at the wrong bit position sets a sticky status flag. That flag drives a maskable interrupt.

The data path uses four outputs to place its shift operations: one-cycle strobes for each rising and falling bit-clock phase, a frame-start strobe, and the bit position.

Top module: `tdm_sync_gen`

## Requirements
- R1: In master mode with both enables high, `bitClk` starts low and then toggles every `divSel`+1 system cycles. Each half bit period is therefore `divSel`+1 cycles long.
- R2: `bitPos` starts at 0 after enabling. It advances by one in the cycle in which `bitClk` goes high, and wraps to 0 after frame length minus 1. The frame length is 8 × `slotCount` bit periods, and a `slotCount` of 0 is treated as 1.
- R3: With `longSync`=0 and `syncOnRise`=1, `frameSync` is high exactly during the high half of bit 0. With `longSync`=0 and `syncOnRise`=0, `frameSync` is high exactly during the low half of the last bit of the frame.
- R4: With `longSync`=1, `frameSync` stays high for W bit periods, where W is `syncWidth` (a value of 0 counts as 1). With `syncOnRise`=1 it is high from the rise that starts bit 0 up to the rise that starts bit W. With `syncOnRise`=0 it is high from the fall inside the last bit up to the fall inside bit W-1.
- R5: `risePhase` and `fallPhase` are each high for one cycle, in the cycle in which `bitClk` has just gone high or low. `frameStart` is high together with the `risePhase` that moves `bitPos` to 0.
- R6: One cycle after `portEn` or `clkEn` is low, `bitClk`, `frameSync` and `bitPos` are 0 and the strobes are idle.
- R7: In slave mode (`masterMode`=0), `bitClk` and `frameSync` are held at 0. `bitPos` advances on each synchronized rise of `extBitClk`. A rise of `extFrameSync`, sampled at those rises, resets `bitPos` to 0.
- R8: In slave mode, a sync rise that lands at a position other than 0 sets `statusFlag`. The first sync rise after enabling is exempt from this check. The flag stays set until cleared. Sync activity in master mode never sets it.
- R9: `irq` is high only when `statusFlag` and `irqEnable` are both high.
- R10: A one-cycle pulse on `statusClr` clears `statusFlag`. When a new unexpected sync arrives in the same cycle, setting the flag takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| portEn | input | 1 | Port enable |
| clkEn | input | 1 | Clock enable |
| masterMode | input | 1 | 1: drive clock and sync, 0: follow external |
| divSel | input | 6 | Half-bit length minus one, in system cycles |
| slotCount | input | 7 | Slots per frame (0 means 1) |
| longSync | input | 1 | 1: multi-bit sync pulse, 0: half-bit pulse |
| syncWidth | input | 3 | Long sync width in bit periods (0 means 1) |
| syncOnRise | input | 1 | 1: sync changes on rising bit-clock edge, 0: on falling |
| irqEnable | input | 1 | Interrupt mask, 1 lets the flag through |
| statusClr | input | 1 | Write-one-to-clear pulse for the status flag |
| extBitClk | input | 1 | External bit clock (slave mode) |
| extFrameSync | input | 1 | External frame sync (slave mode) |
| bitClk | output | 1 | Generated bit clock |
| frameSync | output | 1 | Generated frame sync |
| risePhase | output | 1 | Strobe: bit clock has just gone high |
| fallPhase | output | 1 | Strobe: bit clock has just gone low |
| frameStart | output | 1 | Strobe: bit position has just become 0 |
| bitPos | output | 10 | Bit position within the frame |
| statusFlag | output | 1 | Sticky unexpected-sync flag |
| irq | output | 1 | Masked interrupt |

## Verification
Master timing is tried with directed corners and with seeded random mixes of divider, slot count, sync width and sync edge. The directed corners are the fastest divider, a zero slot count, a zero width and the largest width. Comparing every cycle against a formula model separates errors in the half-bit length from errors in the frame wrap. It also separates errors in the start and end edges of the short and long sync pulses, which differ only in the phase where they toggle.

In slave mode, aligned frames are contrasted with a sync moved to bit 3. This shows that realignment happens in both cases, while only the misplaced sync raises the flag. Mask and clear are then checked on the raised flag, and external sync activity in master mode is checked to leave the flag alone.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  // Per-cycle timing events passed from the phase control to the frame datapath.
  typedef struct packed {
    logic active;    // both enables high
    logic master;    // active and master mode
    logic rise;      // bit clock goes high at the next edge
    logic fall;      // bit clock goes low at the next edge
    logic fsSample;  // synchronized external sync, aligned with rise
  } phaseStrobes_t;
endpackage

// File: rtl/tdm_phase_ctrl.sv
module tdm_phase_ctrl
  import tdm_pkg::*;
#(
  parameter int DIV_W  = 6,
  parameter int SYNC_N = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             portEn,
  input  logic             clkEn,
  input  logic             masterMode,
  input  logic [DIV_W-1:0] divSel,
  input  logic             extBitClk,
  input  logic             extFrameSync,
  output logic             bitClk,
  output phaseStrobes_t    strobes
);
  localparam int FS_N = SYNC_N - 1;

  logic             active;
  logic             masterRun;
  logic             slaveRun;
  logic [DIV_W-1:0] divCnt;
  logic             bitClkQ;
  logic             halfTick;
  logic [SYNC_N-1:0] bitSync;
  logic [FS_N-1:0]   fsSync;
  logic             extRise;
  logic             extFall;

  assign active    = portEn & clkEn;
  assign masterRun = active & masterMode;
  assign slaveRun  = active & ~masterMode;
  assign halfTick  = masterRun & (divCnt >= divSel);

  // Master divider: one toggle of the bit clock per divSel+1 cycles.
  always_ff @(posedge clk) begin
    if (!rstN || !masterRun) begin
      divCnt  <= '0;
      bitClkQ <= 1'b0;
    end else if (halfTick) begin
      divCnt  <= '0;
      bitClkQ <= ~bitClkQ;
    end else begin
      divCnt  <= divCnt + DIV_W'(1);
    end
  end

  // Slave synchronizers for the external clock and sync.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitSync <= '0;
      fsSync  <= '0;
    end else begin
      bitSync <= {bitSync[SYNC_N-2:0], extBitClk};
      fsSync  <= {fsSync[FS_N-2:0], extFrameSync};
    end
  end

  assign extRise = bitSync[SYNC_N-2] & ~bitSync[SYNC_N-1];
  assign extFall = ~bitSync[SYNC_N-2] & bitSync[SYNC_N-1];

  always_comb begin
    strobes.active   = active;
    strobes.master   = masterRun;
    strobes.fsSample = fsSync[FS_N-1];
    if (masterRun) begin
      strobes.rise = halfTick & ~bitClkQ;
      strobes.fall = halfTick & bitClkQ;
    end else begin
      strobes.rise = slaveRun & extRise;
      strobes.fall = slaveRun & extFall;
    end
  end

  assign bitClk = masterRun & bitClkQ;
endmodule

// File: rtl/tdm_frame_dpath.sv
module tdm_frame_dpath
  import tdm_pkg::*;
#(
  parameter int SLOT_W    = 7,
  parameter int SLOT_BITS = 8,
  parameter int WID_W     = 3,
  parameter int POS_W     = SLOT_W + $clog2(SLOT_BITS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  phaseStrobes_t     strobes,
  input  logic [SLOT_W-1:0] slotCount,
  input  logic              longSync,
  input  logic [WID_W-1:0]  syncWidth,
  input  logic              syncOnRise,
  input  logic              statusClr,
  output logic              frameSync,
  output logic              risePhase,
  output logic              fallPhase,
  output logic              frameStart,
  output logic [POS_W-1:0]  bitPos,
  output logic              statusFlag
);
  logic [SLOT_W-1:0] slotEff;
  logic [WID_W-1:0]  widthEff;
  logic [POS_W-1:0]  frameLen;
  logic [POS_W-1:0]  lastPos;
  logic [POS_W-1:0]  pos;
  logic [POS_W-1:0]  nextPos;
  logic [POS_W-1:0]  posNew;
  logic [POS_W-1:0]  syncLimit;
  logic              nextInSync;
  logic              fsQ;
  logic              fsNext;
  logic              fsPrev;
  logic              locked;
  logic              syncEdge;
  logic              unexpected;
  logic              statusQ;
  logic              riseQ;
  logic              fallQ;
  logic              startQ;

  // Frame geometry.
  assign slotEff   = (slotCount == '0) ? SLOT_W'(1) : slotCount;
  assign frameLen  = POS_W'(slotEff) * POS_W'(SLOT_BITS);
  assign lastPos   = frameLen - POS_W'(1);
  assign nextPos   = (pos >= lastPos) ? '0 : pos + POS_W'(1);

  // Sync width in bit periods.
  assign widthEff   = (syncWidth == '0) ? WID_W'(1) : syncWidth;
  assign syncLimit  = longSync ? POS_W'(widthEff) : POS_W'(1);
  assign nextInSync = nextPos < syncLimit;

  // Slave realignment and misplaced-sync detection.
  assign syncEdge   = strobes.rise & ~strobes.master & strobes.fsSample & ~fsPrev;
  assign unexpected = syncEdge & locked & (nextPos != '0);
  assign posNew     = syncEdge ? '0 : nextPos;

  // Master sync level: updated on the selected edge, cut short on the other
  // edge when a half-bit pulse is chosen.
  always_comb begin
    fsNext = fsQ;
    if (strobes.rise) begin
      if (syncOnRise)     fsNext = nextInSync;
      else if (!longSync) fsNext = 1'b0;
    end
    if (strobes.fall) begin
      if (!syncOnRise)    fsNext = nextInSync;
      else if (!longSync) fsNext = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos     <= '0;
      fsQ     <= 1'b0;
      fsPrev  <= 1'b0;
      locked  <= 1'b0;
      riseQ   <= 1'b0;
      fallQ   <= 1'b0;
      startQ  <= 1'b0;
    end else if (!strobes.active) begin
      pos     <= '0;
      fsQ     <= 1'b0;
      fsPrev  <= 1'b0;
      locked  <= 1'b0;
      riseQ   <= 1'b0;
      fallQ   <= 1'b0;
      startQ  <= 1'b0;
    end else begin
      riseQ  <= strobes.rise;
      fallQ  <= strobes.fall;
      startQ <= strobes.rise & (posNew == '0);
      if (strobes.rise) begin
        pos <= posNew;
        if (!strobes.master) begin
          fsPrev <= strobes.fsSample;
          if (syncEdge) locked <= 1'b1;
        end
      end
      fsQ <= strobes.master ? fsNext : 1'b0;
    end
  end

  // Sticky flag: set wins over clear; survives disabling.
  always_ff @(posedge clk) begin
    if (!rstN)           statusQ <= 1'b0;
    else if (unexpected) statusQ <= 1'b1;
    else if (statusClr)  statusQ <= 1'b0;
  end

  assign frameSync  = fsQ & strobes.master;
  assign risePhase  = riseQ;
  assign fallPhase  = fallQ;
  assign frameStart = startQ;
  assign bitPos     = pos;
  assign statusFlag = statusQ;
endmodule

// File: rtl/tdm_sync_gen.sv
module tdm_sync_gen
  import tdm_pkg::*;
#(
  parameter int DIV_W     = 6,
  parameter int SLOT_W    = 7,
  parameter int SLOT_BITS = 8,
  parameter int WID_W     = 3,
  parameter int SYNC_N    = 3,
  localparam int POS_W    = SLOT_W + $clog2(SLOT_BITS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portEn,
  input  logic              clkEn,
  input  logic              masterMode,
  input  logic [DIV_W-1:0]  divSel,
  input  logic [SLOT_W-1:0] slotCount,
  input  logic              longSync,
  input  logic [WID_W-1:0]  syncWidth,
  input  logic              syncOnRise,
  input  logic              irqEnable,
  input  logic              statusClr,
  input  logic              extBitClk,
  input  logic              extFrameSync,
  output logic              bitClk,
  output logic              frameSync,
  output logic              risePhase,
  output logic              fallPhase,
  output logic              frameStart,
  output logic [POS_W-1:0]  bitPos,
  output logic              statusFlag,
  output logic              irq
);
  phaseStrobes_t strobes;

  tdm_phase_ctrl #(.DIV_W(DIV_W), .SYNC_N(SYNC_N)) uCtrl (
    .clk(clk), .rstN(rstN), .portEn(portEn), .clkEn(clkEn),
    .masterMode(masterMode), .divSel(divSel),
    .extBitClk(extBitClk), .extFrameSync(extFrameSync),
    .bitClk(bitClk), .strobes(strobes)
  );

  tdm_frame_dpath #(.SLOT_W(SLOT_W), .SLOT_BITS(SLOT_BITS), .WID_W(WID_W), .POS_W(POS_W)) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .slotCount(slotCount),
    .longSync(longSync), .syncWidth(syncWidth), .syncOnRise(syncOnRise),
    .statusClr(statusClr), .frameSync(frameSync), .risePhase(risePhase),
    .fallPhase(fallPhase), .frameStart(frameStart), .bitPos(bitPos),
    .statusFlag(statusFlag)
  );

  assign irq = statusFlag & irqEnable;
endmodule

// File: rtl/tdm_sync_gen_chk.sv
module tdm_sync_gen_chk #(
  parameter int POS_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             portEn,
  input logic             clkEn,
  input logic             masterMode,
  input logic             irqEnable,
  input logic             statusClr,
  input logic             bitClk,
  input logic             frameSync,
  input logic             risePhase,
  input logic             fallPhase,
  input logic [POS_W-1:0] bitPos,
  input logic             statusFlag,
  input logic             irq
);
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(portEn && clkEn) |=> (!bitClk && !frameSync && bitPos == '0)); // R6
  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(risePhase && fallPhase)); // R5
  AST_RISE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bitClk) |-> risePhase); // R5
  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |-> (!bitClk && !frameSync)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (statusFlag && !statusClr) |=> statusFlag); // R8
  AST_FLAG_SLAVE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusFlag) |-> $past(!masterMode)); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    !irqEnable |-> !irq); // R9
endmodule

bind tdm_sync_gen tdm_sync_gen_chk #(.POS_W(POS_W)) uChk (
  .clk(clk), .rstN(rstN), .portEn(portEn), .clkEn(clkEn),
  .masterMode(masterMode), .irqEnable(irqEnable), .statusClr(statusClr),
  .bitClk(bitClk), .frameSync(frameSync), .risePhase(risePhase),
  .fallPhase(fallPhase), .bitPos(bitPos), .statusFlag(statusFlag), .irq(irq)
);

// File: tb/tb_tdm_sync_gen.sv
module tb_tdm_sync_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       portEn = 1'b0, clkEn = 1'b0, masterMode = 1'b0;
  logic [5:0] divSel = '0;
  logic [6:0] slotCount = 7'd1;
  logic       longSync = 1'b0;
  logic [2:0] syncWidth = '0;
  logic       syncOnRise = 1'b0;
  logic       irqEnable = 1'b0, statusClr = 1'b0;
  logic       extBitClk = 1'b0, extFrameSync = 1'b0;
  logic       bitClk, frameSync, risePhase, fallPhase, frameStart, statusFlag, irq;
  logic [9:0] bitPos;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_sync_gen dut (
    .clk(clk), .rstN(rstN), .portEn(portEn), .clkEn(clkEn), .masterMode(masterMode),
    .divSel(divSel), .slotCount(slotCount), .longSync(longSync), .syncWidth(syncWidth),
    .syncOnRise(syncOnRise), .irqEnable(irqEnable), .statusClr(statusClr),
    .extBitClk(extBitClk), .extFrameSync(extFrameSync), .bitClk(bitClk),
    .frameSync(frameSync), .risePhase(risePhase), .fallPhase(fallPhase),
    .frameStart(frameStart), .bitPos(bitPos), .statusFlag(statusFlag), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected master frame sync after n enabled edges (R3, R4).
  function automatic int expSync(int t, int pos, int len, int lng, int wid, int onRise);
    int w = lng ? ((wid == 0) ? 1 : wid) : 1;
    if (t == 0) return 0;
    if (onRise) begin
      if (!lng) return ((t % 2) == 1 && pos == 0) ? 1 : 0;
      return (pos < w) ? 1 : 0;
    end
    if (!lng) return ((t % 2) == 0 && ((pos + 1) % len) == 0) ? 1 : 0;
    if ((t % 2) == 1) return (t >= 3 && pos < w) ? 1 : 0;
    return (((pos + 1) % len) < w) ? 1 : 0;
  endfunction

  task automatic runMaster(input int dv, input int sc, input int lng, input int wid, input int onRise);
    int h   = dv + 1;
    int len = ((sc == 0) ? 1 : sc) * 8;
    int cyc = 2 * len * 2 * h + 7;
    @(negedge clk);
    portEn = 1'b0; masterMode = 1'b1; clkEn = 1'b1;
    divSel = 6'(dv); slotCount = 7'(sc); longSync = lng[0];
    syncWidth = 3'(wid); syncOnRise = onRise[0];
    repeat (2) @(negedge clk);
    portEn = 1'b1;
    for (int n = 1; n <= cyc; n++) begin
      int t   = n / h;
      int pos = ((t + 1) / 2) % len;
      int tog = ((n % h) == 0) ? 1 : 0;
      int rs  = (tog && (t % 2) == 1) ? 1 : 0;
      int fl  = (tog && (t % 2) == 0) ? 1 : 0;
      @(negedge clk);
      check("R1 bitClk", bitClk, t % 2);
      check("R2 bitPos", bitPos, pos);
      check(lng ? "R4 frameSync long" : "R3 frameSync short", frameSync,
            expSync(t, pos, len, lng, wid, onRise));
      check("R5 risePhase", risePhase, rs);
      check("R5 fallPhase", fallPhase, fl);
      check("R5 frameStart", frameStart, (rs && pos == 0) ? 1 : 0);
    end
  endtask

  task automatic slaveBit(input logic fs);
    @(negedge clk);
    extFrameSync = fs; extBitClk = 1'b0;
    repeat (5) @(negedge clk);
    extBitClk = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check("R6 reset bitClk", bitClk, 0);
    check("R6 reset bitPos", bitPos, 0);
    check("R8 reset statusFlag", statusFlag, 0);
    check("R9 reset irq", irq, 0);
    rstN = 1'b1;

    // Directed corners.
    runMaster(0, 1, 0, 0, 1);
    runMaster(0, 1, 0, 0, 0);
    runMaster(2, 0, 1, 0, 0);
    runMaster(1, 2, 1, 7, 1);
    runMaster(3, 1, 1, 7, 0);
    runMaster(63, 1, 1, 3, 1);
    // Seeded random mixes.
    for (int k = 0; k < 14; k++)
      runMaster($urandom_range(0, 4), $urandom_range(0, 3), $urandom_range(0, 1),
                $urandom_range(0, 7), $urandom_range(0, 1));

    // R6: dropping either enable clears the timing outputs.
    runMaster(0, 1, 1, 2, 1);
    @(negedge clk); clkEn = 1'b0;
    @(negedge clk);
    check("R6 clkEn off bitClk", bitClk, 0);
    check("R6 clkEn off bitPos", bitPos, 0);
    check("R6 clkEn off frameSync", frameSync, 0);
    clkEn = 1'b1;
    repeat (5) @(negedge clk);
    portEn = 1'b0;
    @(negedge clk);
    check("R6 portEn off bitPos", bitPos, 0);
    check("R6 portEn off risePhase", risePhase, 0);

    // Slave mode, one slot per frame.
    masterMode = 1'b0; slotCount = 7'd1; irqEnable = 1'b1;
    extBitClk = 1'b0; extFrameSync = 1'b0;
    repeat (4) @(negedge clk);
    portEn = 1'b1;
    for (int f = 0; f < 3; f++)
      for (int b = 0; b < 8; b++) begin
        slaveBit(b == 0);
        check("R7 slave bitPos", bitPos, b);
        check("R7 slave bitClk quiet", bitClk, 0);
        check("R7 slave frameSync quiet", frameSync, 0);
      end
    check("R8 aligned syncs no flag", statusFlag, 0);
    slaveBit(1'b0); slaveBit(1'b0); slaveBit(1'b0);
    check("R7 slave bitPos before early sync", bitPos, 2);
    slaveBit(1'b1);
    check("R7 slave realign on sync", bitPos, 0);
    check("R8 misplaced sync flag", statusFlag, 1);
    check("R9 irq enabled", irq, 1);
    slaveBit(1'b0);
    check("R8 flag sticky", statusFlag, 1);
    @(negedge clk); irqEnable = 1'b0;
    @(negedge clk);
    check("R9 irq masked", irq, 0);
    check("R9 flag kept while masked", statusFlag, 1);
    statusClr = 1'b1;
    @(negedge clk); statusClr = 1'b0;
    @(negedge clk);
    check("R10 flag cleared", statusFlag, 0);

    // R8: external sync activity in master mode leaves the flag alone.
    masterMode = 1'b1; divSel = 6'd1;
    for (int k = 0; k < 10; k++) slaveBit(k[0]);
    check("R8 master ignores ext sync", statusFlag, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    finished = 1;
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule